// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Pipelined SRAM

This block is a synthesizable behavioural model of a synchronous static memory with one port for reads and another for writes. Every access moves a pair of data words, and both ports take their address from one shared address bus. Both edges of the main memory clock are modelled by a single internal clock running at twice that rate. An internal phase register tags each fast edge either as a main-clock rising edge or as a complement-clock rising edge.

A write is requested on a main edge. The address and the first data word are sampled on that edge, and the second data word is sampled on the complement edge that follows. The words land at the loaded address and at its pair partner, which is the same address with the least significant bit inverted. A read is also requested on a main edge. After a one-period wait it drives two words on consecutive fast edges.

Between bursts the read data output is released: the enable flag drops and the data bus is held at zero. A read that targets a pair whose write is still in flight returns the new data instead of the stale stored contents. A read and a write may be accepted on the same main edge, and in that case they share the one address.

Top module: `sram_b2`

## Requirements
- R1: While reset is held, and until the first read is launched, `q_oe` and `q_valid` are 0 and `rdata` is 0. After reset is released, the first rising edge of `clk` is a main edge.
- R2: When `wr_sel_n` is 0 on a main edge, the `addr` and `wdata` of that edge are stored as word A. The `wdata` of the next complement edge is stored at A with bit 0 inverted. This holds for even and odd A, and back-to-back writes on consecutive main edges are all stored.
- R3: When `rd_sel_n` is 0 on main edge E, `rdata` carries the word at address A from edge E+2 until edge E+3. Edges are counted in `clk` cycles.
- R4: The second read word comes from A with only bit 0 inverted, from edge E+3 until edge E+4. For an odd A this wraps down to the even address of the pair.
- R5: `q_valid` and `q_oe` are 1 for exactly the two beats of every read. Both rise and fall only on main edges. Reads on consecutive main edges keep them at 1 with no gap.
- R6: If no read was accepted on edge E+2, then after the second beat of the read from edge E, `q_oe` and `q_valid` return to 0 at edge E+4 and `rdata` is 0.
- R7: A read accepted on the same main edge as a write to the same address returns the newly written pair. Each beat gets the word written to that beat's own address, with bit 0 of the address choosing the word.
- R8: When both selects are 1 on a main edge, no stored word changes, whatever the values of `addr` and `wdata`. No read burst results from that edge.
- R9: Select inputs that are 0 only on complement edges are ignored. They cause no write and no read.
- R10: `k_slot` is 1 exactly before main edges and alternates on every `clk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; alternate rising edges are main and complement edges |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled on main edges |
| wr_sel_n | input | 1 | Active-low write request, sampled on main edges |
| addr | input | AW | Shared word address, sampled on main edges |
| wdata | input | DW | Write data: first word on a main edge, second word on the complement edge after it |
| k_slot | output | 1 | 1 when the next `clk` rising edge is a main edge |
| rdata | output | DW | Read data beat; 0 while the output is released |
| q_oe | output | 1 | Output drive enable; 0 stands for the high-impedance state |
| q_valid | output | 1 | 1 on each of the two read beats |

## Verification
The bench builds the block with AW=5 and DW=12. A 32-word array keeps addresses short, so odd and even pair members, the wrap of odd addresses and several separate pairs can each be exercised within a few accesses. With twelve-bit data, every word written can carry its own address in its value, so a beat that came from the wrong address or from a stale copy stands out. Forwarding is exercised both with matching pair order and with the odd address, where the bit-0 word selection is swapped.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;
   // Which edge of the memory clock the next fast clock edge stands for
   typedef enum logic {
      SLOT_MAIN = 1'b0,
      SLOT_COMP = 1'b1
   } slot_e;

   // Words moved per access
   localparam int unsigned BEATS = 2;
endpackage

// File: rtl/sram_b2_phase.sv
module sram_b2_phase
   import sram_b2_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   output logic main_edge
);
   slot_e slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= SLOT_MAIN;
      end else begin
         slot_q <= (slot_q == SLOT_MAIN) ? SLOT_COMP : SLOT_MAIN;
      end
   end

   assign main_edge = (slot_q == SLOT_MAIN);
endmodule

// File: rtl/sram_b2_wr.sv
module sram_b2_wr
   import sram_b2_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        main_edge,
   input  logic                        wr_sel_n,
   input  logic [AW-1:0]               addr,
   input  logic [DW-1:0]               wdata,
   output logic                        pend_v,
   output logic [AW-1:0]               pend_a,
   output logic [BEATS-1:0][DW-1:0]    pend_d,
   output logic                        commit
);
   // Stage 1: address and first word, captured on a main edge
   logic          stg_v;
   logic [AW-1:0] stg_a;
   logic [DW-1:0] stg_d0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_v  <= 1'b0;
         stg_a  <= '0;
         stg_d0 <= '0;
      end else if (main_edge) begin
         stg_v  <= ~wr_sel_n;
         stg_a  <= addr;
         stg_d0 <= wdata;
      end else begin
         stg_v  <= 1'b0;
      end
   end

   // Stage 2: complete pair waiting for the next main edge to be committed
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v <= 1'b0;
         pend_a <= '0;
         pend_d <= '0;
      end else if (main_edge) begin
         if (pend_v) begin
            pend_v <= 1'b0;
         end
      end else if (stg_v) begin
         pend_v    <= 1'b1;
         pend_a    <= stg_a;
         pend_d[0] <= stg_d0;
         pend_d[1] <= wdata;
      end
   end

   assign commit = main_edge & pend_v;
endmodule

// File: rtl/sram_b2_array.sv
module sram_b2_array
   import sram_b2_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18
) (
   input  logic                        clk,
   input  logic                        we,
   input  logic [AW-1:0]               waddr,
   input  logic [BEATS-1:0][DW-1:0]    wwords,
   input  logic [AW-1:0]               raddr,
   output logic [BEATS-1:0][DW-1:0]    rwords
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Both words of a pair are written in one edge; they never collide
   always_ff @(posedge clk) begin
      if (we) begin
         for (int b = 0; b < BEATS; b++) begin
            mem[waddr ^ AW'(b)] <= wwords[b];
         end
      end
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_rport
      assign rwords[b] = mem[raddr ^ AW'(b)];
   end
endmodule

// File: rtl/sram_b2_rd.sv
module sram_b2_rd
   import sram_b2_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        main_edge,
   input  logic                        rd_sel_n,
   input  logic [AW-1:0]               addr,
   input  logic [BEATS-1:0][DW-1:0]    mem_q,
   input  logic                        pend_v,
   input  logic [AW-1:0]               pend_a,
   input  logic [BEATS-1:0][DW-1:0]    pend_d,
   output logic [AW-1:0]               rd_a,
   output logic [DW-1:0]               rdata,
   output logic                        q_oe,
   output logic                        q_valid
);
   logic                     req_v;
   logic [AW-1:0]            req_a;
   logic [BEATS-1:0][DW-1:0] beat_w;
   logic [DW-1:0]            q_r;
   logic [DW-1:0]            hold_r;
   logic                     oe_r;
   logic                     second_r;

   // Per-beat choice between the array and the in-flight write pair
   for (genvar b = 0; b < BEATS; b++) begin : g_fwd
      logic [AW-1:0] word_a;
      logic          pair_hit;
      logic          pick;
      assign word_a   = req_a ^ AW'(b);
      assign pair_hit = pend_v && (word_a[AW-1:1] == pend_a[AW-1:1]);
      assign pick     = word_a[0] ^ pend_a[0];
      assign beat_w[b] = pair_hit ? pend_d[pick] : mem_q[b];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_v    <= 1'b0;
         req_a    <= '0;
         q_r      <= '0;
         hold_r   <= '0;
         oe_r     <= 1'b0;
         second_r <= 1'b0;
      end else if (main_edge) begin
         req_v <= ~rd_sel_n;
         req_a <= addr;
         if (req_v) begin
            q_r      <= beat_w[0];
            hold_r   <= beat_w[1];
            oe_r     <= 1'b1;
            second_r <= 1'b1;
         end else begin
            q_r      <= '0;
            oe_r     <= 1'b0;
            second_r <= 1'b0;
         end
      end else if (second_r) begin
         q_r      <= hold_r;
         second_r <= 1'b0;
      end
   end

   assign rd_a    = req_a;
   assign rdata   = q_r;
   assign q_oe    = oe_r;
   assign q_valid = oe_r;
endmodule

// File: rtl/sram_b2.sv
module sram_b2
   import sram_b2_pkg::*;
#(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_sel_n,
   input  logic          wr_sel_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          k_slot,
   output logic [DW-1:0] rdata,
   output logic          q_oe,
   output logic          q_valid
);
   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("sram_b2: AW must lie in 2..12");
   end
   if (DW < 1) begin : g_bad_dw
      $error("sram_b2: DW must be at least 1");
   end

   logic                     main_edge;
   logic                     pend_v;
   logic [AW-1:0]            pend_a;
   logic [BEATS-1:0][DW-1:0] pend_d;
   logic                     commit;
   logic [AW-1:0]            rd_a;
   logic [BEATS-1:0][DW-1:0] mem_q;

   sram_b2_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .main_edge (main_edge)
   );

   sram_b2_wr #(.AW(AW), .DW(DW)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .main_edge (main_edge),
      .wr_sel_n  (wr_sel_n),
      .addr      (addr),
      .wdata     (wdata),
      .pend_v    (pend_v),
      .pend_a    (pend_a),
      .pend_d    (pend_d),
      .commit    (commit)
   );

   sram_b2_array #(.AW(AW), .DW(DW)) u_array (
      .clk    (clk),
      .we     (commit),
      .waddr  (pend_a),
      .wwords (pend_d),
      .raddr  (rd_a),
      .rwords (mem_q)
   );

   sram_b2_rd #(.AW(AW), .DW(DW)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .main_edge (main_edge),
      .rd_sel_n  (rd_sel_n),
      .addr      (addr),
      .mem_q     (mem_q),
      .pend_v    (pend_v),
      .pend_a    (pend_a),
      .pend_d    (pend_d),
      .rd_a      (rd_a),
      .rdata     (rdata),
      .q_oe      (q_oe),
      .q_valid   (q_valid)
   );

   assign k_slot = main_edge;
endmodule

// File: rtl/sram_b2_chk.sv
module sram_b2_chk #(
   parameter int unsigned DW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          k_slot,
   input logic          rd_sel_n,
   input logic [DW-1:0] rdata,
   input logic          q_oe,
   input logic          q_valid
);
   AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      k_slot |=> !k_slot); // R10

   AST_SLOT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      !k_slot |=> k_slot); // R10

   AST_READ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (k_slot && !rd_sel_n) |-> ##3 q_valid); // R3

   AST_NO_SPURIOUS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (k_slot && rd_sel_n) |-> ##3 !q_valid); // R8

   AST_BEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_valid) |=> q_valid); // R5

   AST_EDGES_ON_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(q_valid) || $fell(q_valid)) |-> !k_slot); // R5

   AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !q_oe |-> (rdata == '0)); // R6
endmodule

bind sram_b2 sram_b2_chk #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .k_slot   (k_slot),
   .rd_sel_n (rd_sel_n),
   .rdata    (rdata),
   .q_oe     (q_oe),
   .q_valid  (q_valid)
);

// File: tb/sram_b2_test.sv
`timescale 1ns/1ps
module sram_b2_test;
   localparam int unsigned AW = 5;
   localparam int unsigned DW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          k_slot;
   logic [DW-1:0] rdata;
   logic          q_oe;
   logic          q_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Beats observed during the last period (read issued one period earlier)
   logic [DW-1:0] b0, b1;
   logic          v0, v1, o0, o1, kmid;

   always #2.5 clk = ~clk;

   sram_b2 #(.AW(AW), .DW(DW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_sel_n (rd_sel_n),
      .wr_sel_n (wr_sel_n),
      .addr     (addr),
      .wdata    (wdata),
      .k_slot   (k_slot),
      .rdata    (rdata),
      .q_oe     (q_oe),
      .q_valid  (q_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // One main-clock period; entered and left at a falling edge before a main edge.
   // late=1 moves the selects to the complement edge.
   task automatic kcycle(input logic rs, input logic ws, input logic [AW-1:0] a,
                         input logic [DW-1:0] d0, input logic [DW-1:0] d1, input bit late);
      rd_sel_n = late ? 1'b1 : rs;
      wr_sel_n = late ? 1'b1 : ws;
      addr     = a;
      wdata    = d0;
      @(posedge clk);
      @(negedge clk);
      b0 = rdata; v0 = q_valid; o0 = q_oe; kmid = k_slot;
      wdata    = d1;
      rd_sel_n = late ? rs : 1'b1;
      wr_sel_n = late ? ws : 1'b1;
      @(posedge clk);
      @(negedge clk);
      b1 = rdata; v1 = q_valid; o1 = q_oe;
      rd_sel_n = 1'b1;
      wr_sel_n = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
      kcycle(1'b1, 1'b0, a, d0, d1, 1'b0);
   endtask
   task automatic rd(input logic [AW-1:0] a);
      kcycle(1'b0, 1'b1, a, '0, '0, 1'b0);
   endtask
   task automatic idle();
      kcycle(1'b1, 1'b1, '0, '0, '0, 1'b0);
   endtask

   task automatic expect_pair(input string req, input logic [DW-1:0] e0, input logic [DW-1:0] e1);
      chk({req, " beat0 data"}, 32'(b0), 32'(e0));
      chk({req, " beat1 data"}, 32'(b1), 32'(e1));
      chk({req, " beats valid"}, {30'b0, v0, v1}, 32'h3);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", 32'(q_oe), 32'h0);
      chk("R1 valid in reset", 32'(q_valid), 32'h0);
      rst_n = 1'b1;
      chk("R1 rdata after reset", 32'(rdata), 32'h0);
      chk("R1 first edge is main", 32'(k_slot), 32'h1);
   endtask

   task automatic t_write_read();
      wr(5'd4, 12'h111, 12'h222);
      idle();
      rd(5'd4);
      chk("R10 complement slot", 32'(kmid), 32'h0);
      idle();
      expect_pair("R3 R2 even pair", 12'h111, 12'h222);
      chk("R5 oe on beats", {30'b0, o0, o1}, 32'h3);
   endtask

   task automatic t_wrap();
      wr(5'd9, 12'h909, 12'h808);
      idle();
      rd(5'd9);
      rd(5'd8);
      expect_pair("R4 odd wrap", 12'h909, 12'h808);
      idle();
      expect_pair("R2 odd write", 12'h808, 12'h909);
   endtask

   task automatic t_b2b();
      wr(5'd16, 12'h160, 12'h161);
      wr(5'd20, 12'h200, 12'h201);
      idle();
      rd(5'd16);
      rd(5'd20);
      expect_pair("R5 first of two", 12'h160, 12'h161);
      idle();
      expect_pair("R5 second no gap", 12'h200, 12'h201);
      idle();
      chk("R6 released valid", {30'b0, v0, v1}, 32'h0);
      chk("R6 released oe", {30'b0, o0, o1}, 32'h0);
      chk("R6 released data", 32'(b0 | b1), 32'h0);
   endtask

   task automatic t_forward();
      wr(5'd12, 12'h0C0, 12'h0C1);
      idle();
      kcycle(1'b0, 1'b0, 5'd12, 12'h5C0, 12'h5C1, 1'b0);
      idle();
      expect_pair("R7 same edge even", 12'h5C0, 12'h5C1);
      kcycle(1'b0, 1'b0, 5'd13, 12'h7D1, 12'h7D0, 1'b0);
      idle();
      expect_pair("R7 same edge odd", 12'h7D1, 12'h7D0);
      rd(5'd12);
      idle();
      expect_pair("R7 stored after forward", 12'h7D0, 12'h7D1);
   endtask

   task automatic t_idle();
      kcycle(1'b1, 1'b1, 5'd4, 12'hFFF, 12'hEEE, 1'b0);
      idle();
      chk("R8 no burst from idle", {30'b0, v0, v1}, 32'h0);
      rd(5'd4);
      idle();
      expect_pair("R8 memory unchanged", 12'h111, 12'h222);
   endtask

   task automatic t_late();
      kcycle(1'b0, 1'b0, 5'd4, 12'hABC, 12'hABD, 1'b1);
      idle();
      chk("R9 late read ignored", {30'b0, v0, v1}, 32'h0);
      rd(5'd4);
      idle();
      expect_pair("R9 late write ignored", 12'h111, 12'h222);
   endtask

   initial begin
      t_reset();
      t_write_read();
      t_wrap();
      t_b2b();
      t_forward();
      t_idle();
      t_late();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule